// File: doc/BRIEF.md
# Masked Logical Channel Combiner

The block samples sixteen single-bit detector hit lines once per bunch-crossing clock (40 MHz), blanks any line whose mask bit is set, and merges the remaining lines into logical channels. The logical channels are the OR of adjacent inputs in groups of two, four or eight. The group size is chosen at run time. Groups of two drive all eight outputs. Groups of four drive outputs 0 to 3. Groups of eight drive outputs 0 and 1. Any output that the chosen group size does not use is held low.

For rate monitoring, every input also feeds a saturating rate counter. Each counter counts rising edges of the raw input, before the mask is applied. Software reaches the block through a byte-wide address/data bus. Through that bus it writes the mask and the group size, clears all counters at once, and takes a snapshot of one counter. It then reads the snapshot as three bytes. A two-state snapshot sequencer guards the read: state `SNAP_EMPTY` moves to `SNAP_HELD` on a take command (transition *take*). `SNAP_HELD` stays in `SNAP_HELD` on a new take (transition *retake*). `SNAP_HELD` returns to `SNAP_EMPTY` when the high byte is read (transition *release*).

The mask, the group size and the sequencer state are each stored as three copies. Every clock rewrites all three copies with their majority value, so a single upset copy is repaired on the next edge. Three test inputs can invert one chosen copy of one chosen bit, so that this repair can be exercised.

Top module: `lch_combiner`

## Requirements
- R1: After reset, `lch_out` is 0, the mask (addresses 0 and 1) reads 0, the group mode (address 2) reads 0, and the snapshot bytes (addresses 4 to 6) read 0.
- R2: A set mask bit (address 0 holds inputs 7..0, address 1 holds inputs 15..8) forces its input to 0 before grouping.
- R3: In mode 0, `lch_out[i]` is the OR of inputs 2i and 2i+1. It reflects inputs that were stable across two consecutive rising clock edges.
- R4: In mode 1, `lch_out[i]` for i = 0..3 is the OR of inputs 4i..4i+3. In mode 2, `lch_out[i]` for i = 0..1 is the OR of inputs 8i..8i+7. In both modes every other output is 0.
- R5: The mode is written at address 2 through `wdata[1:0]`. A write is ignored when that value is 3 or when any of `wdata[7:2]` is set.
- R6: Each counter increments once per rising edge of its unmasked input, no matter how long the input stays high and whether the input is masked.
- R7: A counter that has reached its all-ones value stays there and does not wrap.
- R8: A write to address 3 with bit 5 set and bits 7:6 clear zeroes all sixteen counters on the same edge. A rising edge on that same edge is lost. When bits 7:6 are not both clear, the command is ignored.
- R9: A write to address 3 with bit 4 set and bits 7:6 clear copies the counter selected by bits 3:0 into the snapshot. The value copied is the count before that edge. The snapshot reads as bits 7:0 at address 4, bits 15:8 at address 5 and bits 23:16 at address 6.
- R10: The snapshot bytes read 0 in `SNAP_EMPTY`. A read strobe (`bus_rd`) at address 6 in `SNAP_HELD` returns to `SNAP_EMPTY`, unless a take happens on the same edge.
- R11: Inverting one copy of a stored bit with the upset inputs does not change the read value or the outputs. The copy is repaired on the next edge, so a later upset of a different copy of the same bit is also harmless. Bit indices are: 0..15 mask, 16..17 mode, 18 sequencer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pch_in | input | 16 | Physical channel hit inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used to release the snapshot) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| lch_out | output | 8 | Logical channel outputs, registered |
| upset_en | input | 1 | Invert one stored copy on this edge |
| upset_copy | input | 2 | Copy to invert (0..2; 3 selects none) |
| upset_idx | input | 5 | Stored bit to invert |

## Verification
Two pairs of functions can land on the same edge. The first pair is a counter clear and a rising input edge. The bench raises an input and issues the clear on the edge where the rise is first seen; the counter must read zero and must not count the held level later. The second pair is a snapshot take and a counter increment. The bench issues the take on the edge where the counter steps; the snapshot must show the old count, and a second take must show the new one.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
    localparam int N_PCH  = 16;
    localparam int N_LCH  = N_PCH / 2;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int SNAP_W = 3 * DATA_W;

    typedef enum logic [1:0] {
        GRP_OR2 = 2'd0,
        GRP_OR4 = 2'd1,
        GRP_OR8 = 2'd2
    } grp_mode_e;

    typedef enum logic {
        SNAP_EMPTY = 1'b0,
        SNAP_HELD  = 1'b1
    } snap_state_e;

    localparam logic [ADDR_W-1:0] ADR_MASK_LO = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_MASK_HI = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_MODE    = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_CMD     = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_SNAP_LO = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_SNAP_MD = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_SNAP_HI = 4'd6;
endpackage

// File: rtl/tmr_reg.sv
module tmr_reg #(
    parameter int W = 1,
    parameter logic [W-1:0] RST = '0,
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [W-1:0]  d,
    input  logic          upset_en,
    input  logic [1:0]    upset_copy,
    input  logic [IW-1:0] upset_idx,
    output logic [W-1:0]  q
);
    logic [W-1:0] cp  [3];
    logic [W-1:0] nxt [3];

    assign q = (cp[0] & cp[1]) | (cp[0] & cp[2]) | (cp[1] & cp[2]);

    always_comb begin
        for (int c = 0; c < 3; c++) begin
            nxt[c] = we ? d : q;
            if (upset_en && upset_copy == 2'(c) && 32'(upset_idx) < W)
                nxt[c][upset_idx] = ~nxt[c][upset_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) cp[c] <= RST;
        end else begin
            for (int c = 0; c < 3; c++) cp[c] <= nxt[c];
        end
    end

    // R11: copies agree again one edge after any upset
    assert_copies_repaired_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(upset_en) |-> (cp[0] == cp[1] && cp[1] == cp[2]));
endmodule

// File: rtl/rate_counter.sv
module rate_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     count <= '0;
        else if (clr)                   count <= '0;
        else if (rise && count != TOP)  count <= count + 1'b1;
    end

    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> count >= $past(count));
endmodule

// File: rtl/lch_merge.sv
module lch_merge import lcc_pkg::*; (
    input  logic [N_PCH-1:0] pass,
    input  grp_mode_e        mode,
    output logic [N_LCH-1:0] lch
);
    localparam int G4 = N_PCH / 4;
    localparam int G8 = N_PCH / 8;

    logic [N_LCH-1:0] or2;
    logic [G4-1:0]    or4;
    logic [G8-1:0]    or8;

    for (genvar i = 0; i < N_LCH; i++) begin : g_or2
        assign or2[i] = |pass[2*i +: 2];
    end
    for (genvar i = 0; i < G4; i++) begin : g_or4
        assign or4[i] = |pass[4*i +: 4];
    end
    for (genvar i = 0; i < G8; i++) begin : g_or8
        assign or8[i] = |pass[8*i +: 8];
    end

    always_comb begin
        unique case (mode)
            GRP_OR2: lch = or2;
            GRP_OR4: lch = N_LCH'(or4);
            GRP_OR8: lch = N_LCH'(or8);
            default: lch = '0;
        endcase
    end
endmodule

// File: rtl/lch_combiner.sv
module lch_combiner import lcc_pkg::*; #(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PCH-1:0]  pch_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_LCH-1:0]  lch_out,
    input  logic              upset_en,
    input  logic [1:0]        upset_copy,
    input  logic [4:0]        upset_idx
);
    localparam int SEL_W = $clog2(N_PCH);

    // input sampling and edge detection
    logic [N_PCH-1:0] hit_q, hit_d1, rise, pass;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= '0;
            hit_d1 <= '0;
        end else begin
            hit_q  <= pch_in;
            hit_d1 <= hit_q;
        end
    end
    assign rise = hit_q & ~hit_d1;

    // bus decode
    logic wr_mlo, wr_mhi, wr_mode, cmd_ok, cnt_clr, snap_take, rd_hi;
    logic [SEL_W-1:0] snap_sel;
    assign wr_mlo    = bus_wr && bus_addr == ADR_MASK_LO;
    assign wr_mhi    = bus_wr && bus_addr == ADR_MASK_HI;
    assign wr_mode   = bus_wr && bus_addr == ADR_MODE && bus_wdata[7:2] == '0
                       && bus_wdata[1:0] != 2'b11;
    assign cmd_ok    = bus_wr && bus_addr == ADR_CMD && bus_wdata[7:6] == 2'b00;
    assign cnt_clr   = cmd_ok && bus_wdata[5];
    assign snap_take = cmd_ok && bus_wdata[4];
    assign snap_sel  = bus_wdata[SEL_W-1:0];
    assign rd_hi     = bus_rd && bus_addr == ADR_SNAP_HI;

    // voted configuration
    logic [N_PCH-1:0] mask_q, mask_d;
    logic [1:0]       mode_bits;
    logic [0:0]       state_bits;
    logic             up_mask, up_mode, up_state;
    grp_mode_e        mode_q;
    snap_state_e      state_q, state_nxt;

    assign up_mask  = upset_en && upset_idx < 5'd16;
    assign up_mode  = upset_en && upset_idx[4:1] == 4'b1000;
    assign up_state = upset_en && upset_idx == 5'd18;
    assign mask_d   = {wr_mhi ? bus_wdata : mask_q[15:8], wr_mlo ? bus_wdata : mask_q[7:0]};

    tmr_reg #(.W(N_PCH), .RST('0), .IW(4)) u_mask (
        .clk(clk), .rst_n(rst_n), .we(wr_mlo | wr_mhi), .d(mask_d),
        .upset_en(up_mask), .upset_copy(upset_copy), .upset_idx(upset_idx[3:0]),
        .q(mask_q));

    tmr_reg #(.W(2), .RST(2'b00), .IW(1)) u_mode (
        .clk(clk), .rst_n(rst_n), .we(wr_mode), .d(bus_wdata[1:0]),
        .upset_en(up_mode), .upset_copy(upset_copy), .upset_idx(upset_idx[0]),
        .q(mode_bits));

    tmr_reg #(.W(1), .RST(1'b0), .IW(1)) u_state (
        .clk(clk), .rst_n(rst_n), .we(1'b1), .d(state_nxt),
        .upset_en(up_state), .upset_copy(upset_copy), .upset_idx(1'b0),
        .q(state_bits));

    assign mode_q  = grp_mode_e'(mode_bits);
    assign state_q = snap_state_e'(state_bits);

    // snapshot sequencer: next-state process
    always_comb begin
        unique case (state_q)
            SNAP_EMPTY: state_nxt = snap_take ? SNAP_HELD : SNAP_EMPTY;
            SNAP_HELD:  state_nxt = snap_take ? SNAP_HELD :
                                    (rd_hi ? SNAP_EMPTY : SNAP_HELD);
            default:    state_nxt = SNAP_EMPTY;
        endcase
    end

    // rate counters
    logic [CNT_W-1:0] cnt [N_PCH];
    for (genvar g = 0; g < N_PCH; g++) begin : g_cnt
        rate_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .rise(rise[g]), .clr(cnt_clr), .count(cnt[g]));
    end

    logic [SNAP_W-1:0] snap_q, snap_vis;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         snap_q <= '0;
        else if (snap_take) snap_q <= SNAP_W'(cnt[snap_sel]);
    end

    // snapshot sequencer: output process
    always_comb begin
        unique case (state_q)
            SNAP_HELD: snap_vis = snap_q;
            default:   snap_vis = '0;
        endcase
    end

    always_comb begin
        case (bus_addr)
            ADR_MASK_LO: bus_rdata = mask_q[7:0];
            ADR_MASK_HI: bus_rdata = mask_q[15:8];
            ADR_MODE:    bus_rdata = {6'b0, mode_bits};
            ADR_SNAP_LO: bus_rdata = snap_vis[7:0];
            ADR_SNAP_MD: bus_rdata = snap_vis[15:8];
            ADR_SNAP_HI: bus_rdata = snap_vis[23:16];
            default:     bus_rdata = '0;
        endcase
    end

    // masking and grouping
    logic [N_LCH-1:0] lch_nxt;
    assign pass = hit_q & ~mask_q;
    lch_merge u_merge (.pass(pass), .mode(mode_q), .lch(lch_nxt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lch_out <= '0;
        else        lch_out <= lch_nxt;
    end

    assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == GRP_OR2 && mask_q[1:0] == 2'b11) |=> !lch_out[0]);
    assert_or4_upper_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == GRP_OR4) |=> lch_out[N_LCH-1:4] == '0);
    assert_or8_upper_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == GRP_OR8) |=> lch_out[N_LCH-1:2] == '0);
    assert_mode_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bits != 2'b11);
    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNAP_HELD && rd_hi && !snap_take && !upset_en) |=> state_q == SNAP_EMPTY);
endmodule

// File: tb/tb_lch_combiner.sv
module tb_lch_combiner;
    localparam int CLK_PERIOD = 25;
    localparam int CW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pch_in = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  lch_out;
    logic        upset_en = 1'b0;
    logic [1:0]  upset_copy = '0;
    logic [4:0]  upset_idx = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    lch_combiner #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .pch_in(pch_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lch_out(lch_out), .upset_en(upset_en), .upset_copy(upset_copy),
        .upset_idx(upset_idx));

    always #(CLK_PERIOD/2) clk = ~clk;

    // {mask, mode, pch, expected lch}
    localparam logic [41:0] VEC [11] = '{
        {16'h0000, 2'd0, 16'h0001, 8'h01},
        {16'h0000, 2'd0, 16'h8002, 8'h81},
        {16'h0000, 2'd0, 16'h0C30, 8'h24},
        {16'h0001, 2'd0, 16'h0001, 8'h00},
        {16'h0000, 2'd1, 16'h0100, 8'h04},
        {16'h0000, 2'd1, 16'hF001, 8'h09},
        {16'h000F, 2'd1, 16'h001F, 8'h02},
        {16'h0000, 2'd2, 16'h0080, 8'h01},
        {16'h0000, 2'd2, 16'hFFFF, 8'h03},
        {16'hFF00, 2'd2, 16'hFF00, 8'h00},
        {16'h7FFF, 2'd2, 16'hFFFF, 8'h02}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // caller stands at a falling edge
    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic strobe, output logic [7:0] d);
        bus_addr = a; bus_rd = strobe;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int ch);
        pch_in[ch] = 1'b1; @(negedge clk);
        pch_in[ch] = 1'b0; @(negedge clk);
    endtask

    task automatic snap_read(input int ch, output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        bus_write(4'd3, 8'h10 | 8'(ch));
        bus_read(4'd4, 1'b0, b0);
        bus_read(4'd5, 1'b0, b1);
        bus_read(4'd6, 1'b1, b2);
        v = {b2, b1, b0};
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rb;
        logic [23:0] sv;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 lch", 32'(lch_out), 0);
        bus_read(4'd0, 1'b0, rb); check("R1 mask lo", 32'(rb), 0);
        bus_read(4'd1, 1'b0, rb); check("R1 mask hi", 32'(rb), 0);
        bus_read(4'd2, 1'b0, rb); check("R1 mode", 32'(rb), 0);
        bus_read(4'd4, 1'b0, rb); check("R1 snapshot", 32'(rb), 0);

        // R2 R3 R4 vector walk
        for (int i = 0; i < 11; i++) begin
            logic [15:0] m, p; logic [1:0] md; logic [7:0] e;
            {m, md, p, e} = VEC[i];
            bus_write(4'd0, m[7:0]);
            bus_write(4'd1, m[15:8]);
            bus_write(4'd2, {6'b0, md});
            pch_in = p;
            idle(2);
            check($sformatf("R2/R3/R4 vector %0d", i), 32'(lch_out), 32'(e));
        end

        // R5 reserved mode values ignored
        bus_write(4'd0, 8'h00); bus_write(4'd1, 8'h00);
        bus_write(4'd2, 8'h01);
        bus_write(4'd2, 8'h03);
        bus_read(4'd2, 1'b0, rb); check("R5 mode 3 ignored", 32'(rb), 1);
        bus_write(4'd2, 8'h04);
        bus_read(4'd2, 1'b0, rb); check("R5 upper bits ignored", 32'(rb), 1);
        pch_in = 16'h0100; idle(2);
        check("R5 still OR4", 32'(lch_out), 32'h04);

        // R6 edge counting, masked channel still counts
        pch_in = '0; bus_write(4'd2, 8'h00); idle(2);
        bus_write(4'd3, 8'h20);
        for (int k = 0; k < 5; k++) pulse(3);
        pch_in[3] = 1'b1; idle(4); pch_in[3] = 1'b0; idle(2);
        snap_read(3, sv); check("R6 edges not levels", 32'(sv), 6);
        bus_write(4'd1, 8'h02);
        for (int k = 0; k < 3; k++) begin
            pch_in[9] = 1'b1; idle(2);
            check("R2 masked ch9 blocked", 32'(lch_out[4]), 0);
            pch_in[9] = 1'b0; idle(1);
        end
        snap_read(9, sv); check("R6 masked still counts", 32'(sv), 3);
        bus_write(4'd1, 8'h00);

        // R10 release after high byte read
        bus_read(4'd4, 1'b0, rb); check("R10 empty after release", 32'(rb), 0);

        // R8 reserved command ignored
        bus_write(4'd3, 8'h60);
        snap_read(3, sv); check("R8 guarded clear ignored", 32'(sv), 6);

        // R8 clear coincides with rise
        pch_in[3] = 1'b1; @(negedge clk);
        bus_write(4'd3, 8'h20);
        idle(3);
        snap_read(3, sv); check("R8 clear beats rise", 32'(sv), 0);
        snap_read(9, sv); check("R8 clears all", 32'(sv), 0);
        pch_in[3] = 1'b0; idle(2);

        // R9 take coincides with increment
        pch_in[3] = 1'b1; @(negedge clk);
        bus_write(4'd3, 8'h13);
        bus_read(4'd4, 1'b0, rb); check("R9 pre-edge value", 32'(rb), 0);
        bus_read(4'd6, 1'b1, rb);
        pch_in[3] = 1'b0; idle(1);
        snap_read(3, sv); check("R9 after increment", 32'(sv), 1);

        // R7 saturation and byte layout
        for (int k = 0; k < 1030; k++) pulse(5);
        snap_read(5, sv); check("R7 R9 saturate bytes", 32'(sv), 32'h0003FF);

        // R11 upset repair
        bus_write(4'd2, 8'h00); bus_write(4'd0, 8'h00);
        pch_in = 16'h0004; idle(2);
        check("R11 baseline", 32'(lch_out), 32'h02);
        upset_idx = 5'd2; upset_copy = 2'd0; upset_en = 1'b1; @(negedge clk);
        upset_copy = 2'd1; @(negedge clk);
        upset_en = 1'b0;
        bus_read(4'd0, 1'b0, rb); check("R11 mask unchanged", 32'(rb), 0);
        idle(1);
        check("R11 output unchanged", 32'(lch_out), 32'h02);
        upset_idx = 5'd17; upset_copy = 2'd2; upset_en = 1'b1; @(negedge clk);
        upset_copy = 2'd0; @(negedge clk);
        upset_en = 1'b0;
        bus_read(4'd2, 1'b0, rb); check("R11 mode unchanged", 32'(rb), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule